// File: doc/BRIEF.md
# Flash Memory Controller Register Interface

This block places a behavioural on-chip flash array behind a simple memory-mapped bus port and governs every change to it. A two-bit mode register chooses between read-only access, a program mode and an erase mode. Command registers start a single-page erase, an erase of the separate user configuration page, or an erase of the whole array. A bus master that wants to program the array writes 32-bit words into the flash address window while program mode is active.

Each accepted program or erase holds the ready flag low for a fixed number of cycles, set by a parameter. A full-array erase uses its own, longer parameter. The master polls the ready register before it issues the next command or mode change. Erased cells read as all ones. Programming can only clear bits, so a master can pad a partial word with ones and leave the neighbouring bytes untouched. The main array sits at `MAIN_BASE` and the configuration page sits at `CFG_BASE`. The registers sit at `REG_BASE` plus fixed offsets.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the ready flag is 1, the mode reads 0 and every word of the main array and of the configuration page reads 0xFFFFFFFF.
- R2: A write to offset 0x504 sets the mode from wdata[1:0]: 0 is read-only, 1 is program enable and 2 is erase enable. The same offset reads the mode back in bits [1:0], and a mode write does not drop ready.
- R3: Offset 0x400 reads ready in bit 0 with every other bit zero. It reads 0 while an operation runs and 1 when the block is idle.
- R4: In mode 1, a word-aligned write inside the main window or the configuration window stores the old word ANDed with wdata. Ready is then low for exactly OP_CYCLES cycles.
- R5: An array write is ignored and leaves ready high if the mode is not 1 or if bus_addr[1:0] is nonzero.
- R6: In mode 2, a write to offset 0x508 whose data is an address inside the main window sets every word of that 1024-byte page to all ones. Other pages are unchanged and ready is low for OP_CYCLES cycles.
- R7: A page-erase request whose data lies outside the main window, including an address in the configuration page, is ignored and leaves ready high.
- R8: In mode 2, writing a value with bit 0 set to offset 0x514 erases the configuration page only, with ready low for OP_CYCLES cycles. A value with bit 0 clear is ignored.
- R9: In mode 2, writing a value with bit 0 set to offset 0x50C erases the main array and the configuration page, with ready low for FULL_CYCLES cycles.
- R10: Erase commands issued in any mode other than 2 are ignored and leave ready high.
- R11: While ready is low, every bus write is ignored, including writes to the mode register.
- R12: A read of an unmapped address, or of a command register, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ready | output | 1 | Same value as bit 0 of the ready register |

## Verification
Reads are combinational and have no side effects. The bench therefore samples them shortly after a falling edge, in the same half cycle as the request, and no rising edge lies between the request and the sample. A write is accepted on the one rising edge during which bus_valid is held, and its array effect is visible at the next falling edge. From that edge the ready register reads 0 for exactly OP_CYCLES consecutive falling edges, or FULL_CYCLES for a full erase. The bench counts those falling edges and compares the count with the parameter. Writes that should be ignored are followed at once by a ready read and a read-back of the affected words, before any further stimulus.

// File: rtl/nvm_ctrl.sv
module nvm_ctrl #(
  parameter int          PAGE_WORDS  = 256,
  parameter int          MAIN_PAGES  = 4,
  parameter int          OP_CYCLES   = 8,
  parameter int          FULL_CYCLES = 40,
  parameter logic [31:0] MAIN_BASE   = 32'h0000_0000,
  parameter logic [31:0] CFG_BASE    = 32'h1000_1000,
  parameter logic [31:0] REG_BASE    = 32'h4001_E000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        ready
);
  localparam int          MAIN_WORDS  = PAGE_WORDS * MAIN_PAGES;
  localparam int          TOTAL_WORDS = MAIN_WORDS + PAGE_WORDS;
  localparam int          IDX_W       = $clog2(TOTAL_WORDS);
  localparam int          CNT_W       = $clog2(FULL_CYCLES + 1);
  localparam logic [31:0] PAGE_BYTES  = 32'(PAGE_WORDS * 4);
  localparam logic [31:0] MAIN_BYTES  = 32'(MAIN_WORDS * 4);
  localparam logic [31:0] A_READY     = REG_BASE + 32'h400;
  localparam logic [31:0] A_MODE      = REG_BASE + 32'h504;
  localparam logic [31:0] A_ERPAGE    = REG_BASE + 32'h508;
  localparam logic [31:0] A_ERALL     = REG_BASE + 32'h50C;
  localparam logic [31:0] A_ERCFG     = REG_BASE + 32'h514;
  localparam logic [1:0]  M_RO = 2'd0, M_WEN = 2'd1, M_EEN = 2'd2;

  logic [31:0]      mem [TOTAL_WORDS];
  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      main_off, cfg_off, pe_off, pe_first;
  logic             main_hit, cfg_hit, wr, prog;
  logic             erase_page, erase_cfg, erase_all;
  logic [IDX_W-1:0] widx;

  assign ready    = (cnt == '0);
  assign main_off = bus_addr - MAIN_BASE;
  assign cfg_off  = bus_addr - CFG_BASE;
  assign pe_off   = bus_wdata - MAIN_BASE;
  assign main_hit = main_off < MAIN_BYTES;
  assign cfg_hit  = cfg_off < PAGE_BYTES;
  assign widx     = main_hit ? IDX_W'(main_off >> 2)
                             : IDX_W'((cfg_off >> 2) + 32'(MAIN_WORDS));
  assign pe_first = (pe_off / PAGE_BYTES) * 32'(PAGE_WORDS);

  assign wr         = bus_valid && bus_write && ready;
  assign prog       = wr && mode == M_WEN && (main_hit || cfg_hit) && bus_addr[1:0] == 2'b00;
  assign erase_page = wr && mode == M_EEN && bus_addr == A_ERPAGE && pe_off < MAIN_BYTES;
  assign erase_cfg  = wr && mode == M_EEN && bus_addr == A_ERCFG && bus_wdata[0];
  assign erase_all  = wr && mode == M_EEN && bus_addr == A_ERALL && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_RO;
      cnt  <= '0;
      for (int i = 0; i < TOTAL_WORDS; i++) mem[i] <= '1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (wr && bus_addr == A_MODE) mode <= bus_wdata[1:0];
      if (prog) begin
        mem[widx] <= mem[widx] & bus_wdata;
        cnt       <= CNT_W'(OP_CYCLES);
      end
      if (erase_page || erase_cfg) cnt <= CNT_W'(OP_CYCLES);
      if (erase_all) cnt <= CNT_W'(FULL_CYCLES);
      for (int i = 0; i < TOTAL_WORDS; i++) begin
        if (erase_all || (erase_cfg && i >= MAIN_WORDS) ||
            (erase_page && 32'(i) >= pe_first && 32'(i) < pe_first + 32'(PAGE_WORDS)))
          mem[i] <= '1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (main_hit || cfg_hit)  bus_rdata = mem[widx];
      else if (bus_addr == A_READY) bus_rdata = {31'b0, ready};
      else if (bus_addr == A_MODE)  bus_rdata = {30'b0, mode};
    end
  end

  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(mode));

  p_locked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && ready && mode == M_RO) |=> ready);

  p_unaligned_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && ready && bus_addr[1:0] != 2'b00) |=> ready);

  p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FULL_CYCLES));

  p_busy_needs_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(mode) == M_WEN || $past(mode) == M_EEN));

  p_cfg_erase_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && ready && mode == M_EEN && bus_addr == A_ERCFG && bus_wdata[0])
    |=> !ready);
endmodule

// File: tb/test_nvm_ctrl.sv
module test_nvm_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          OPC  = 8;
  localparam int          FULC = 40;
  localparam logic [31:0] CFG  = 32'h1000_1000;
  localparam logic [31:0] REG  = 32'h4001_E000;
  localparam logic [31:0] R_READY = REG + 32'h400, R_MODE = REG + 32'h504,
                          R_ERPG  = REG + 32'h508, R_ERALL = REG + 32'h50C,
                          R_ERCFG = REG + 32'h514;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        ready;
  int          tests = 0, fails = 0;

  nvm_ctrl #(.OP_CYCLES(OPC), .FULL_CYCLES(FULC)) i_nvm_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] d;
    n = 0;
    rd(R_READY, d);
    while (d[0] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
      rd(R_READY, d);
    end
  endtask

  task automatic wait_ready();
    int n;
    busy_len(n);
  endtask

  task automatic expect_word(input string req, input logic [31:0] a, input logic [31:0] e);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, e);
  endtask

  task automatic t_reset();
    expect_word("R1/R3 ready after reset", R_READY, 32'h1);
    expect_word("R1 mode after reset", R_MODE, 32'h0);
    expect_word("R1 main erased", 32'h0000_0010, 32'hFFFF_FFFF);
    expect_word("R1 cfg erased", CFG + 32'h8, 32'hFFFF_FFFF);
  endtask

  task automatic t_mode();
    wr(R_MODE, 32'h1);
    expect_word("R2 mode 1", R_MODE, 32'h1);
    expect_word("R2 mode write keeps ready", R_READY, 32'h1);
    wr(R_MODE, 32'hFFFF_FFF2);
    expect_word("R2 mode 2", R_MODE, 32'h2);
    wr(R_MODE, 32'h0);
    expect_word("R2 mode 0", R_MODE, 32'h0);
  endtask

  task automatic t_program();
    int n;
    wr(R_MODE, 32'h1);
    wr(32'h0000_0010, 32'h1234_5678);
    busy_len(n);
    chk("R4 program busy length", 32'(n), 32'(OPC));
    expect_word("R4 program value", 32'h0000_0010, 32'h1234_5678);
    wr(32'h0000_0010, 32'hFFFF_00FF);
    busy_len(n);
    chk("R3 busy length second word", 32'(n), 32'(OPC));
    expect_word("R4 program ANDs", 32'h0000_0010, 32'h1234_0078);
    wr(CFG + 32'h8, 32'hA5A5_A5A5); wait_ready();
    expect_word("R4 program cfg page", CFG + 32'h8, 32'hA5A5_A5A5);
    wr(32'h0000_0400, 32'h0); wait_ready();
    wr(32'h0000_0800, 32'h0); wait_ready();
    expect_word("R4 program page 2", 32'h0000_0800, 32'h0);
  endtask

  task automatic t_prog_ignored();
    wr(R_MODE, 32'h0);
    wr(32'h0000_0020, 32'h0);
    expect_word("R5 read-only write keeps ready", R_READY, 32'h1);
    expect_word("R5 read-only write ignored", 32'h0000_0020, 32'hFFFF_FFFF);
    wr(R_MODE, 32'h1);
    wr(32'h0000_0022, 32'h0);
    expect_word("R5 unaligned keeps ready", R_READY, 32'h1);
    expect_word("R5 unaligned ignored", 32'h0000_0020, 32'hFFFF_FFFF);
    wr(R_MODE, 32'h2);
    wr(32'h0000_0024, 32'h0);
    expect_word("R5 erase-mode write ignored", 32'h0000_0024, 32'hFFFF_FFFF);
  endtask

  task automatic t_page_erase();
    int n;
    wr(R_MODE, 32'h2);
    wr(R_ERPG, 32'h0000_0400);
    busy_len(n);
    chk("R6 page erase busy length", 32'(n), 32'(OPC));
    expect_word("R6 page erased", 32'h0000_0400, 32'hFFFF_FFFF);
    expect_word("R6 page 0 kept", 32'h0000_0010, 32'h1234_0078);
    expect_word("R6 page 2 kept", 32'h0000_0800, 32'h0);
  endtask

  task automatic t_page_erase_outside();
    wr(R_ERPG, CFG);
    expect_word("R7 cfg via page erase keeps ready", R_READY, 32'h1);
    expect_word("R7 cfg not erased", CFG + 32'h8, 32'hA5A5_A5A5);
    wr(R_ERPG, 32'h0000_1000);
    expect_word("R7 beyond main keeps ready", R_READY, 32'h1);
  endtask

  task automatic t_erase_gated();
    wr(R_MODE, 32'h1);
    wr(R_ERALL, 32'h1);
    expect_word("R10 full erase in mode 1 keeps ready", R_READY, 32'h1);
    expect_word("R10 full erase in mode 1 ignored", 32'h0000_0010, 32'h1234_0078);
    wr(R_MODE, 32'h0);
    wr(R_ERCFG, 32'h1);
    expect_word("R10 cfg erase in mode 0 ignored", CFG + 32'h8, 32'hA5A5_A5A5);
    wr(R_ERPG, 32'h0000_0800);
    expect_word("R10 page erase in mode 0 ignored", 32'h0000_0800, 32'h0);
  endtask

  task automatic t_cfg_erase();
    int n;
    wr(R_MODE, 32'h2);
    wr(R_ERCFG, 32'h0);
    expect_word("R8 bit0 clear keeps ready", R_READY, 32'h1);
    expect_word("R8 bit0 clear ignored", CFG + 32'h8, 32'hA5A5_A5A5);
    wr(R_ERCFG, 32'h1);
    busy_len(n);
    chk("R8 cfg erase busy length", 32'(n), 32'(OPC));
    expect_word("R8 cfg erased", CFG + 32'h8, 32'hFFFF_FFFF);
    expect_word("R8 main kept", 32'h0000_0010, 32'h1234_0078);
  endtask

  task automatic t_busy_block();
    wr(R_MODE, 32'h1);
    wr(32'h0000_0030, 32'h0);
    wr(R_MODE, 32'h2);
    wr(32'h0000_0034, 32'h0);
    wait_ready();
    expect_word("R11 mode write while busy ignored", R_MODE, 32'h1);
    expect_word("R11 program while busy ignored", 32'h0000_0034, 32'hFFFF_FFFF);
    expect_word("R11 first program done", 32'h0000_0030, 32'h0);
  endtask

  task automatic t_full_erase();
    int n;
    wr(CFG + 32'h4, 32'h0); wait_ready();
    wr(R_MODE, 32'h2);
    wr(R_ERALL, 32'h1);
    busy_len(n);
    chk("R9 full erase busy length", 32'(n), 32'(FULC));
    expect_word("R9 word 0x10 erased", 32'h0000_0010, 32'hFFFF_FFFF);
    expect_word("R9 word 0x30 erased", 32'h0000_0030, 32'hFFFF_FFFF);
    expect_word("R9 page 2 erased", 32'h0000_0800, 32'hFFFF_FFFF);
    expect_word("R9 cfg erased", CFG + 32'h4, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    expect_word("R12 command register reads 0", R_ERPG, 32'h0);
    expect_word("R12 unmapped reads 0", 32'h2000_0000, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_program();
    t_prog_ignored();
    t_page_erase();
    t_page_erase_outside();
    t_erase_gated();
    t_cfg_erase();
    t_busy_block();
    t_full_erase();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule